// File: doc/BRIEF.md
# Integrating Input Level Detector

This block measures the average magnitude of a stream of signed input samples so that software can run an automatic gain control loop. Each accepted sample is rectified to its magnitude. A programmable threshold is subtracted from it, and the signed difference is summed into a wide accumulator over a programmed number of samples, N. When the Nth sample of a period arrives, the top 23 bits of the sum are copied into a holding register and a ready flag is raised. A processor then reads the held value as three bytes. Reading the top byte drops the flag.

The period counter has two modes. In one-shot mode it stops after one period. This lets software start a measurement on a system event, such as the start of a burst, by writing the period. In continuous mode it reloads at the end of each period and keeps producing results. A period write restarts the measurement at any time. It never produces a result by itself. With a threshold of zero, the result is the plain summed magnitude. With a nonzero threshold, it is the summed error against that level, and the error can be negative.

Top module: `level_detector`

## Requirements
- R1: A sample's magnitude is its two's-complement absolute value. The most negative code (-32768 at the default width) gives the largest positive magnitude (32767) instead of wrapping.
- R2: Each accepted sample adds (magnitude - threshold) to a signed accumulator, with the threshold taken from register bytes 3 (low) and 4 (high). The threshold uses the low SAMPLE_W-1 bits.
- R3: The accumulator starts every period at zero. On the Nth accepted sample of a period, bits [31:9] of the sum that includes that sample (the top 23 of 32 at default width) are copied to the holding register. Cycles with sample_valid low are not counted.
- R4: In one-shot mode (write byte 2, bit 0 = 0), the counter stops after the Nth sample. Later samples change neither the held result nor the flag.
- R5: In continuous mode (write byte 2, bit 0 = 1), the counter reloads N after each terminal sample and keeps running. Each period gives its own result.
- R6: Writing write byte 1 (period high byte) loads N = {data, last value written to write byte 0}, clears the accumulator and starts counting. A write of N = 0 stops the counter. Such a write never copies to the holding register or sets the flag. A sample offered in the same cycle as this write is dropped.
- R7: The ready flag (read byte 3, bit 0) is set when a result is latched. It is cleared only by a read of read byte 2 (the top byte). Reads of read bytes 0, 1 and 3 leave it set.
- R8: When a latch and a top-byte read fall in the same cycle, the flag stays set.
- R9: The result reads as 24 bits: read byte 0 = bits 7:0, read byte 1 = bits 15:8, read byte 2 = bits 23:16, with bit 23 a copy of bit 22 (sign extension). Read data appears on rd_data the cycle after rd_en. Read byte 3 bit 1 shows that the counter is running.
- R10: After reset, the result is zero, the flag is clear, the counter is stopped, the mode is one-shot, and the threshold and period are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Marks sample_in as a new sample |
| sample_in | input | SAMPLE_W | Signed input sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write byte select (0 period low, 1 period high and start, 2 mode, 3/4 threshold) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read byte select (0..2 result, 3 status) |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The bench applies the most negative input code. A design that negated it without saturating would add a large negative term and return a wildly wrong result. It restarts a one-shot measurement halfway through a period. A design that latched on the restart, or kept the old partial sum, would raise the flag early or return a value covering the wrong samples. It puts a top-byte read in the same cycle as a terminal sample, where a clear-wins flag would lose the new result. It runs continuous periods with random thresholds and gaps in the sample stream, which exposes a counter that counts idle cycles, fails to reload, or drops the sign of a negative error.

// File: rtl/ld_pkg.sv
package ld_pkg;
    localparam int CNT_W  = 16;
    localparam int RES_W  = 23;
    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_CONT    = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        WA_PER_LO = 3'd0,
        WA_PER_HI = 3'd1,
        WA_MODE   = 3'd2,
        WA_THR_LO = 3'd3,
        WA_THR_HI = 3'd4
    } wr_sel_e;

    typedef enum logic [1:0] {
        RA_RES_LO  = 2'd0,
        RA_RES_MID = 2'd1,
        RA_RES_HI  = 2'd2,
        RA_STATUS  = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic running;
        logic ready;
    } status_t;

    function automatic logic [BYTE_W-1:0] status_byte(input status_t s);
        return {{(BYTE_W-2){1'b0}}, s.running, s.ready};
    endfunction
endpackage

// File: rtl/ld_rectify.sv
module ld_rectify #(
    parameter int SAMPLE_W = 16,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [MAG_W-1:0]    threshold,
    output logic signed [SAMPLE_W-1:0] term
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] negated;
    logic [MAG_W-1:0]    mag;

    always_comb begin
        negated = -sample;
        if (!sample[SAMPLE_W-1])
            mag = sample[MAG_W-1:0];
        else if (sample == MOST_NEG)
            mag = {MAG_W{1'b1}};
        else
            mag = negated[MAG_W-1:0];
        term = $signed({1'b0, mag}) - $signed({1'b0, threshold});
    end
endmodule

// File: rtl/ld_period_ctrl.sv
module ld_period_ctrl
    import ld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] period_in,
    input  mode_e            mode,
    input  logic             sample_valid,
    output logic             running,
    output logic             accept,
    output logic             terminal
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             running_q;

    assign running  = running_q;
    assign accept   = running_q && sample_valid && !start;
    assign terminal = accept && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            reload_q  <= '0;
        end else if (start) begin
            running_q <= (period_in != '0);
            cnt_q     <= period_in;
            reload_q  <= period_in;
        end else if (accept) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_q <= reload_q;
                if (mode == MODE_ONESHOT)
                    running_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (rst)
        (terminal && mode == MODE_ONESHOT) |=> !running_q);

    assert_cont_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (terminal && mode == MODE_CONT) |=> (running_q && cnt_q == $past(reload_q)));

    assert_count_live_R3: assert property (@(posedge clk) disable iff (rst)
        running_q |-> (cnt_q != '0));
endmodule

// File: rtl/ld_accum.sv
module ld_accum
    import ld_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    localparam int ACC_W   = SAMPLE_W + CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       accept,
    input  logic                       terminal,
    input  logic signed [SAMPLE_W-1:0] term,
    input  logic                       msb_read,
    output logic        [RES_W-1:0]    hold,
    output logic                       ready
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum;
    logic        [RES_W-1:0] hold_q;
    logic                    ready_q;

    assign sum   = acc_q + ACC_W'(term);
    assign hold  = hold_q;
    assign ready = ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (start || terminal) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q <= sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            if (terminal)
                hold_q <= sum[ACC_W-1 -: RES_W];
            if (terminal)
                ready_q <= 1'b1;
            else if (msb_read)
                ready_q <= 1'b0;
        end
    end

    assert_restart_no_latch_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> ($stable(hold_q) && !$rose(ready_q)));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        terminal |=> ready_q);

    assert_msb_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (msb_read && !terminal) |=> !ready_q);

    assert_period_fresh_R3: assert property (@(posedge clk) disable iff (rst)
        (start || terminal) |=> (acc_q == '0));
endmodule

// File: rtl/level_detector.sv
module level_detector
    import ld_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    input  logic [1:0]          rd_addr,
    output logic [7:0]          rd_data
);
    localparam int MAG_W = SAMPLE_W - 1;
    localparam int THR_W = 2 * BYTE_W;

    logic [BYTE_W-1:0]    per_lo_q;
    mode_e                mode_q;
    logic [THR_W-1:0]     thr_q;
    logic [BYTE_W-1:0]    rd_data_q;
    logic                 start;
    logic [CNT_W-1:0]     period_in;
    logic                 running, accept, terminal, msb_read, ready;
    logic signed [SAMPLE_W-1:0] term;
    logic [RES_W-1:0]     hold;
    logic [3*BYTE_W-1:0]  result24;
    status_t              status;

    assign start     = wr_en && (wr_addr == WA_PER_HI);
    assign period_in = CNT_W'({wr_data, per_lo_q});
    assign msb_read  = rd_en && (rd_addr == RA_RES_HI);
    assign result24  = {hold[RES_W-1], hold};
    assign status    = '{running: running, ready: ready};
    assign rd_data   = rd_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_lo_q <= '0;
            mode_q   <= MODE_ONESHOT;
            thr_q    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WA_PER_LO: per_lo_q <= wr_data;
                WA_MODE:   mode_q   <= mode_e'(wr_data[0]);
                WA_THR_LO: thr_q[BYTE_W-1:0]      <= wr_data;
                WA_THR_HI: thr_q[THR_W-1:BYTE_W]  <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                RA_RES_LO:  rd_data_q <= result24[7:0];
                RA_RES_MID: rd_data_q <= result24[15:8];
                RA_RES_HI:  rd_data_q <= result24[23:16];
                default:    rd_data_q <= status_byte(status);
            endcase
        end
    end

    ld_rectify #(.SAMPLE_W(SAMPLE_W)) u_rect (
        .sample    (sample_in),
        .threshold (thr_q[MAG_W-1:0]),
        .term      (term)
    );

    ld_period_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .period_in    (period_in),
        .mode         (mode_q),
        .sample_valid (sample_valid),
        .running      (running),
        .accept       (accept),
        .terminal     (terminal)
    );

    ld_accum #(.SAMPLE_W(SAMPLE_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .accept   (accept),
        .terminal (terminal),
        .term     (term),
        .msb_read (msb_read),
        .hold     (hold),
        .ready    (ready)
    );

    assert_read_sign_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && rd_addr == RA_RES_HI) |-> (rd_data[7] == rd_data[6]));
endmodule

// File: tb/level_detector_tb.sv
module level_detector_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [15:0] sample_in;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    longint model_sum;
    int     model_thr;

    always #4 clk = ~clk;

    level_detector u_dut (.*);

    function automatic int mag_of(input int s);
        if (s == -32768) return 32767;
        return (s < 0) ? -s : s;
    endfunction

    function automatic logic [23:0] expect_res(input longint sum);
        longint sh;
        sh = sum >>> 9;
        return sh[23:0];
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic rd_result(output logic [23:0] r);
        logic [7:0] b0, b1, b2;
        rd(2'd0, b0); rd(2'd1, b1); rd(2'd2, b2);
        r = {b2, b1, b0};
    endtask

    task automatic send(input int s);
        sample_valid = 1; sample_in = 16'(s);
        model_sum += longint'(mag_of(s) - model_thr);
        @(negedge clk);
        sample_valid = 0;
    endtask

    task automatic set_thr(input int t);
        wr(3'd3, 8'(t)); wr(3'd4, 8'(t >> 8));
        model_thr = t;
    endtask

    task automatic start_period(input int n);
        wr(3'd0, 8'(n)); wr(3'd1, 8'(n >> 8));
        model_sum = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  st;
        logic [23:0] r, last;
        void'($urandom(32'd1234));
        rst = 1; sample_valid = 0; sample_in = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_en = 0; rd_addr = 0;
        model_sum = 0; model_thr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10 reset state
        rd(2'd3, st); check("R10 status after reset", st, 0);
        rd_result(r); check("R10 result after reset", r, 0);

        // R1 R3 R9: one-shot, threshold 0, includes most negative code
        set_thr(0); wr(3'd2, 8'h00);
        start_period(4);
        send(100); send(-200);
        sample_valid = 0; @(negedge clk);           // idle cycle not counted (R3)
        send(-32768); send(5);
        rd(2'd3, st); check("R7 flag set after latch", st[0], 1);
        check("R4 stopped after one-shot period", st[1], 0);
        rd(2'd0, st); rd(2'd3, st); check("R7 low byte read keeps flag", st[0], 1);
        rd_result(r); check("R1 R3 saturated magnitude sum", r, expect_res(model_sum));
        rd(2'd3, st); check("R7 top byte read clears flag", st[0], 0);
        last = r;

        // R4: samples after a one-shot period are ignored
        send(30000); send(-30000);
        rd(2'd3, st); check("R4 no new flag after halt", st[0], 0);
        rd_result(r); check("R4 result unchanged after halt", r, last);

        // R6: restart mid-period does not latch, clears partial sum
        set_thr(1000);
        start_period(4);
        send(20000); send(-15000);
        start_period(3);
        rd(2'd3, st); check("R6 restart raises no flag", st[0], 0);
        check("R6 running after restart", st[1], 1);
        rd_result(r); check("R6 restart does not latch", r, last);
        send(50); send(-70); send(900);             // negative error sum
        rd(2'd3, st); check("R3 flag after three samples", st[0], 1);
        rd_result(r); check("R2 R9 negative sign-extended result", r, expect_res(model_sum));
        check("R9 bit 23 copies bit 22", r[23], r[22]);

        // R8: terminal sample and top-byte read in the same cycle
        set_thr(0);
        start_period(2);
        send(1234);
        sample_valid = 1; sample_in = 16'd4321; rd_en = 1; rd_addr = 2'd2;
        model_sum += 4321;
        @(negedge clk);
        sample_valid = 0; rd_en = 0;
        rd(2'd3, st); check("R8 set wins over clear", st[0], 1);
        rd_result(r); check("R8 new result kept", r, expect_res(model_sum));

        // R5 R2: continuous mode, random thresholds and gaps
        wr(3'd2, 8'h01);
        set_thr(int'($urandom_range(0, 20000)));
        start_period(5);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 5; k++) begin
                if ($urandom_range(0, 2) == 0) begin
                    sample_valid = 0; @(negedge clk);
                end
                send(int'($signed(16'($urandom))));
            end
            rd(2'd3, st);
            check("R5 flag each continuous period", st[0], 1);
            check("R5 still running", st[1], 1);
            rd_result(r);
            check("R5 R2 continuous period result", r, expect_res(model_sum));
            model_sum = 0;
        end

        // R6: period 0 write stops the counter
        start_period(0);
        rd(2'd3, st); check("R6 zero period stops counter", st[1], 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule